// File: doc/BRIEF.md
# Dynamic Priority Interrupt Resolver

The resolver picks one winning interrupt line out of up to three banks of 32 lines for a single requested output class, either the normal class or the fast class. Each line brings a pending bit, a mask bit, a class bit and a small priority value. The lines that qualify for the requested class compete on priority, and the block reports the global number of the winner together with a flag that says whether any line qualified.

The caller supplies packed per-line vectors and the class to resolve. Both classes read the same priority table. A caller that needs both winners uses two instances, or time-shares one, and changes only `class_i`. The selection is a tournament tree per bank followed by a merge across banks. The result is registered, so it appears one clock after the inputs are sampled.

Top module: `intr_resolver`

## Requirements
- R1: Line g is a candidate only when `pend_i[g]` is 1, `mask_i[g]` is 0 and `fiq_sel_i[g]` equals `class_i`, where the value 1 means the fast class and 0 means the normal class. A masked line, or a line of the other class, never wins.
- R2: Among candidates, the line with the numerically smallest priority wins. The value 0 is the most urgent. Line g's priority is `prio_i[g*PRIO_W +: PRIO_W]`.
- R3: Among candidates of equal priority, the line with the highest global number wins.
- R4: The reported index is 32 times the bank number plus the bit position within the bank. Line g is bit g of the packed vectors and belongs to bank g/32.
- R5: With no candidate, `idx_o` is 0.
- R6: `valid_o` is 1 exactly when at least one candidate existed, so that a real line 0 can be told apart from the idle case.
- R7: Every priority value qualifies, including the all-ones value (63 for the default width). A lone candidate at that priority is reported.
- R8: The outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges. While `rst_ni` is low they are `idx_o`=0 and `valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| class_i | input | 1 | Class being resolved (1 fast, 0 normal) |
| pend_i | input | NUM_BANKS*32 | Pending bit per line |
| mask_i | input | NUM_BANKS*32 | Mask bit per line (1 blocks the line) |
| fiq_sel_i | input | NUM_BANKS*32 | Class bit per line |
| prio_i | input | NUM_BANKS*32*PRIO_W | Priority field per line, packed by line number |
| idx_o | output | $clog2(NUM_BANKS*32) | Global number of the winning line |
| valid_o | output | 1 | At least one candidate existed |

## Verification
A wrong comparison or tie-break in one tree node, or a wrong bank offset in the merge, shows as a wrong `idx_o`. This happens only for input patterns that route the competition through that node. For this reason the stimulus mixes fully pending banks at equal priority with sparse random patterns that use few distinct priority values. Any such fault is visible one clock after the offending inputs are applied, because the block holds no other state. A fault in the qualify stage shows as `valid_o` set with no candidate present, or as a masked or wrong-class line being reported.

// File: rtl/intr_res_pkg.sv
package intr_res_pkg;
  localparam int unsigned BANK_LINES = 32;
  localparam int unsigned POS_W      = $clog2(BANK_LINES);
  localparam int unsigned MAX_BANKS  = 3;

  typedef enum logic {
    CLS_NORM = 1'b0,
    CLS_FAST = 1'b1
  } intr_class_e;
endpackage

// File: rtl/intr_qualify.sv
module intr_qualify #(
  parameter int unsigned LINES = 32
) (
  input  logic             class_i,
  input  logic [LINES-1:0] pend_i,
  input  logic [LINES-1:0] mask_i,
  input  logic [LINES-1:0] fiq_sel_i,
  output logic [LINES-1:0] cand_o
);
  logic [LINES-1:0] cls_match;

  assign cls_match = ~(fiq_sel_i ^ {LINES{class_i}});
  assign cand_o    = pend_i & ~mask_i & cls_match;
endmodule

// File: rtl/intr_bank_tree.sv
module intr_bank_tree
  import intr_res_pkg::*;
#(
  parameter int unsigned PRIO_W = 6
) (
  input  logic [BANK_LINES-1:0]        cand_i,
  input  logic [BANK_LINES*PRIO_W-1:0] prio_i,
  output logic                         vld_o,
  output logic [POS_W-1:0]             pos_o,
  output logic [PRIO_W-1:0]            prio_o
);
  localparam int unsigned LVLS = POS_W;

  for (genvar s = 0; s <= LVLS; s++) begin : g_lvl
    localparam int unsigned N = BANK_LINES >> s;
    logic              v [N];
    logic [POS_W-1:0]  p [N];
    logic [PRIO_W-1:0] q [N];

    if (s == 0) begin : g_leaf
      for (genvar k = 0; k < N; k++) begin : g_k
        assign v[k] = cand_i[k];
        assign p[k] = POS_W'(k);
        assign q[k] = prio_i[k*PRIO_W +: PRIO_W];
      end
    end else begin : g_node
      for (genvar k = 0; k < N; k++) begin : g_k
        logic take_hi;
        // upper child holds the higher line numbers: it wins ties
        assign take_hi = g_lvl[s-1].v[2*k+1] &
                         (~g_lvl[s-1].v[2*k] |
                          (g_lvl[s-1].q[2*k+1] <= g_lvl[s-1].q[2*k]));
        assign v[k] = g_lvl[s-1].v[2*k] | g_lvl[s-1].v[2*k+1];
        assign p[k] = take_hi ? g_lvl[s-1].p[2*k+1] : g_lvl[s-1].p[2*k];
        assign q[k] = take_hi ? g_lvl[s-1].q[2*k+1] : g_lvl[s-1].q[2*k];
      end
    end
  end

  assign vld_o  = g_lvl[LVLS].v[0];
  assign pos_o  = g_lvl[LVLS].p[0];
  assign prio_o = g_lvl[LVLS].q[0];
endmodule

// File: rtl/intr_bank_merge.sv
module intr_bank_merge
  import intr_res_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned PRIO_W    = 6,
  parameter int unsigned IDX_W     = $clog2(NUM_BANKS*BANK_LINES)
) (
  input  logic              bvld_i  [NUM_BANKS],
  input  logic [POS_W-1:0]  bpos_i  [NUM_BANKS],
  input  logic [PRIO_W-1:0] bprio_i [NUM_BANKS],
  output logic              vld_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic              best_v;
  logic [IDX_W-1:0]  best_i;
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_v = 1'b0;
    best_i = '0;
    best_p = '0;
    // ascending bank order; later bank wins ties
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (bvld_i[b] && (!best_v || bprio_i[b] <= best_p)) begin
        best_v = 1'b1;
        best_p = bprio_i[b];
        best_i = IDX_W'(b * int'(BANK_LINES) + int'(bpos_i[b]));
      end
    end
  end

  assign vld_o = best_v;
  assign idx_o = best_v ? best_i : '0;
endmodule

// File: rtl/intr_resolver.sv
module intr_resolver
  import intr_res_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned PRIO_W    = 6,
  localparam int unsigned LINES    = NUM_BANKS * BANK_LINES,
  localparam int unsigned IDX_W    = $clog2(LINES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    class_i,
  input  logic [LINES-1:0]        pend_i,
  input  logic [LINES-1:0]        mask_i,
  input  logic [LINES-1:0]        fiq_sel_i,
  input  logic [LINES*PRIO_W-1:0] prio_i,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    valid_o
);
  logic [LINES-1:0]  cand;
  logic              bvld  [NUM_BANKS];
  logic [POS_W-1:0]  bpos  [NUM_BANKS];
  logic [PRIO_W-1:0] bprio [NUM_BANKS];
  logic              win_v;
  logic [IDX_W-1:0]  win_i;

  intr_qualify #(.LINES(LINES)) u_qual (
    .class_i  (class_i),
    .pend_i   (pend_i),
    .mask_i   (mask_i),
    .fiq_sel_i(fiq_sel_i),
    .cand_o   (cand)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    intr_bank_tree #(.PRIO_W(PRIO_W)) u_tree (
      .cand_i(cand[b*BANK_LINES +: BANK_LINES]),
      .prio_i(prio_i[b*BANK_LINES*PRIO_W +: BANK_LINES*PRIO_W]),
      .vld_o (bvld[b]),
      .pos_o (bpos[b]),
      .prio_o(bprio[b])
    );
  end

  intr_bank_merge #(
    .NUM_BANKS(NUM_BANKS),
    .PRIO_W   (PRIO_W),
    .IDX_W    (IDX_W)
  ) u_merge (
    .bvld_i (bvld),
    .bpos_i (bpos),
    .bprio_i(bprio),
    .vld_o  (win_v),
    .idx_o  (win_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      idx_o   <= win_i;
      valid_o <= win_v;
    end
  end
endmodule

// File: rtl/intr_resolver_chk.sv
module intr_resolver_chk
  import intr_res_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned PRIO_W    = 6,
  localparam int unsigned LINES    = NUM_BANKS * BANK_LINES,
  localparam int unsigned IDX_W    = $clog2(LINES)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    class_i,
  input logic [LINES-1:0]        pend_i,
  input logic [LINES-1:0]        mask_i,
  input logic [LINES-1:0]        fiq_sel_i,
  input logic [LINES*PRIO_W-1:0] prio_i,
  input logic [IDX_W-1:0]        idx_o,
  input logic                    valid_o
);
  logic [LINES-1:0]        cand_q;
  logic [LINES*PRIO_W-1:0] prio_q;
  logic                    lower_exists;
  logic                    tie_above;
  logic                    in_range;
  logic                    win_cand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      prio_q <= '0;
    end else begin
      for (int g = 0; g < int'(LINES); g++)
        cand_q[g] <= pend_i[g] && !mask_i[g] && (fiq_sel_i[g] == class_i);
      prio_q <= prio_i;
    end
  end

  assign in_range = int'(idx_o) < int'(LINES);

  always_comb begin
    logic [PRIO_W-1:0] wp;
    lower_exists = 1'b0;
    tie_above    = 1'b0;
    win_cand     = 1'b0;
    wp           = '0;
    for (int g = 0; g < int'(LINES); g++) begin
      if (g == int'(idx_o)) begin
        wp       = prio_q[g*PRIO_W +: PRIO_W];
        win_cand = cand_q[g];
      end
    end
    for (int g = 0; g < int'(LINES); g++) begin
      if (cand_q[g] && prio_q[g*PRIO_W +: PRIO_W] < wp) lower_exists = 1'b1;
      if (cand_q[g] && prio_q[g*PRIO_W +: PRIO_W] == wp && g > int'(idx_o))
        tie_above = 1'b1;
    end
  end

  p_cand_winner_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> win_cand);
  p_min_prio_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !lower_exists);
  p_tie_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !tie_above);
  p_idx_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_range);
  p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (idx_o == '0));
  p_valid_any_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (cand_q != '0));
endmodule

bind intr_resolver intr_resolver_chk #(
  .NUM_BANKS(NUM_BANKS),
  .PRIO_W   (PRIO_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .class_i  (class_i),
  .pend_i   (pend_i),
  .mask_i   (mask_i),
  .fiq_sel_i(fiq_sel_i),
  .prio_i   (prio_i),
  .idx_o    (idx_o),
  .valid_o  (valid_o)
);

// File: tb/sim_intr_resolver.sv
module sim_intr_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int NB    = 3;
  localparam int PW    = 6;
  localparam int LINES = NB * 32;
  localparam int IW    = $clog2(LINES);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 cls;
  logic [LINES-1:0]     pend, mask, fsel;
  logic [LINES*PW-1:0]  prio;
  logic [IW-1:0]        idx;
  logic                 vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_resolver #(.NUM_BANKS(NB), .PRIO_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .class_i(cls), .pend_i(pend),
    .mask_i(mask), .fiq_sel_i(fsel), .prio_i(prio),
    .idx_o(idx), .valid_o(vld)
  );

  function automatic int ref_win();
    int best = -1;
    int bp = 255;
    for (int g = 0; g < LINES; g++) begin
      if (pend[g] && !mask[g] && (fsel[g] == cls)) begin
        if (int'(prio[g*PW +: PW]) <= bp) begin
          bp = int'(prio[g*PW +: PW]);
          best = g;
        end
      end
    end
    return best;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  endtask

  task automatic clear_in();
    cls = 1'b0; pend = '0; mask = '0; fsel = '0; prio = '0;
  endtask

  // result appears after the next rising edge
  task automatic step_ref(string req);
    int e;
    e = ref_win();
    @(posedge clk); #1;
    check(req, int'(idx), (e < 0) ? 0 : e);
    check(req, int'(vld), (e >= 0) ? 1 : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_in();
    pend = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R8", int'(idx), 0);
    check("R8", int'(vld), 0);

    @(negedge clk); rst_n = 1'b1; clear_in();
    @(posedge clk); #1;
    check("R5", int'(idx), 0);
    check("R6", int'(vld), 0);

    // lone line 0 at the largest priority
    @(negedge clk); clear_in(); pend[0] = 1'b1; prio[0 +: PW] = '1;
    @(posedge clk); #1;
    check("R7", int'(idx), 0);
    check("R7", int'(vld), 1);

    // bank 2, bit 5
    @(negedge clk); clear_in(); pend[69] = 1'b1; prio[69*PW +: PW] = 6'd5;
    @(posedge clk); #1;
    check("R4", int'(idx), 69);

    // all pending at equal priority
    @(negedge clk); clear_in(); pend = '1;
    @(posedge clk); #1;
    check("R3", int'(idx), 95);

    @(negedge clk); mask[95] = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(idx), 94);

    @(negedge clk); fsel[94] = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(idx), 93);

    @(negedge clk); cls = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(idx), 94);

    // wrong class only
    @(negedge clk); clear_in(); pend[5] = 1'b1; fsel[5] = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(vld), 0);
    check("R5", int'(idx), 0);

    @(negedge clk); clear_in();
    pend[10] = 1'b1; prio[10*PW +: PW] = 6'd3;
    pend[80] = 1'b1; prio[80*PW +: PW] = 6'd7;
    @(posedge clk); #1;
    check("R2", int'(idx), 10);

    // output holds until the next edge
    @(negedge clk); clear_in(); #1;
    check("R8", int'(idx), 10);
    check("R8", int'(vld), 1);
    @(posedge clk); #1;
    check("R8", int'(vld), 0);

    for (int it = 0; it < 600; it++) begin
      int c;
      @(negedge clk);
      cls = 1'($urandom);
      c = int'($urandom % 64);
      for (int b = 0; b < NB; b++) begin
        pend[b*32 +: 32] = (it % 4 == 0) ? ($urandom & $urandom & $urandom) : $urandom;
        mask[b*32 +: 32] = $urandom & $urandom;
        fsel[b*32 +: 32] = $urandom;
      end
      for (int g = 0; g < LINES; g++) begin
        if (it % 3 == 0)      prio[g*PW +: PW] = PW'(c);
        else if (it % 3 == 1) prio[g*PW +: PW] = PW'($urandom % 4);
        else                  prio[g*PW +: PW] = PW'($urandom);
      end
      step_ref((it % 3 == 0) ? "R3" : "R2");
    end

    finish_run();
  end
endmodule